// File: doc/BRIEF.md
# Segmented Interleaved Dual-Port RAM

A simple dual-port memory cut into a parameterized number of independent segments that share one wide data path. Every segment owns a write command channel and a read command channel, each with its own valid/ready handshake, plus a read response channel with its own valid/ready pair. Consecutive segment-width words of the flat byte space rotate across the segments. A word held by segment `s` at segment address `a` therefore sits at byte address `(a * SEG_CNT + s) * bytes_per_segment`.

Writes go through per-lane byte enables. Each accepted write is confirmed by a one-cycle done pulse on that segment's bit. Reads pass through a one-entry pipeline stage into a held response register, so one segment can be stalled by its consumer while the other segments keep flowing. Both ports run in one clock domain with an active-low asynchronous reset.

Top module: `seg_dp_ram`

## Requirements
- R1: All handshake and done signals are vectors with one bit per segment. The address, data and byte-enable buses are concatenations of per-segment fields, with segment 0 in the least significant field.
- R2: A word written through segment `s` at segment address `a` lives at flat byte address `(a*SEG_CNT+s)*SEG_DW/8`. Reading segment `s` at address `a` returns it.
- R3: Bytes are little-endian within a field: byte lane `k` of a segment occupies bits `[8k+7:8k]`, and its write enable is bit `k` of that segment's byte-enable field. Only lanes with the enable set change. An all-zero enable changes nothing.
- R4: A write fires on a segment when its valid and ready are both high. Exactly one cycle later that segment's done bit is high, and it is high only in cycles that follow a fire.
- R5: A read command accepted while the segment's pipeline and response slot are both empty raises response valid after the second rising edge: it is still low after the first edge, high after the second.
- R6: While a segment's response valid is high and its response ready is low, valid stays high and the response data holds.
- R7: Write command ready is high whenever out of reset. Read command ready is high when the response slot is empty or the pipeline stage is free, and low when both are full.
- R8: While reset is asserted, every ready, response valid and done output is low, and any pending response is dropped.
- R9: If a read and a write hit the same word in the same cycle, the read returns the data from before the write.
- R10: Backpressure on one segment's response does not stall reads on any other segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | SEG_CNT | Write command valid per segment |
| wr_ready_o | output | SEG_CNT | Write command ready per segment |
| wr_addr_i | input | SEG_CNT*SEG_AW | Per-segment write word addresses |
| wr_data_i | input | SEG_CNT*SEG_DW | Per-segment write data |
| wr_be_i | input | SEG_CNT*SEG_DW/8 | Per-segment byte enables |
| wr_done_o | output | SEG_CNT | One-cycle write completion pulse per segment |
| rd_valid_i | input | SEG_CNT | Read command valid per segment |
| rd_ready_o | output | SEG_CNT | Read command ready per segment |
| rd_addr_i | input | SEG_CNT*SEG_AW | Per-segment read word addresses |
| rd_data_o | output | SEG_CNT*SEG_DW | Per-segment response data |
| rd_rvalid_o | output | SEG_CNT | Response valid per segment |
| rd_rready_i | input | SEG_CNT | Response ready per segment |

## Verification
The done bit of a segment is due one rising edge after its write fires. Read data is due two edges after the command is accepted into an empty segment, and the first edge must leave response valid low. The bench drives inputs and samples outputs on falling edges, so each check lands half a cycle after the edge that should have produced its result. Under backpressure it holds response ready low for several cycles and samples valid, data and command ready at every falling edge. It then releases the stall and expects the queued word one edge later and an empty slot one edge after that.

// File: rtl/seg_dp_ram_pkg.sv
package seg_dp_ram_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/seg_bank.sv
module seg_bank
  import seg_dp_ram_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW/BYTE_W-1:0] wbe_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int LANES = DW / BYTE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (wbe_i[l]) mem_q[waddr_i][l*BYTE_W +: BYTE_W] <= wdata_i[l*BYTE_W +: BYTE_W];
      end
    end
  end

  // registered read: this register is the segment's pipeline stage; old data on collision
  always_ff @(posedge clk_i) begin
    if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/seg_wr_port.sv
module seg_wr_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic ready_o,
  output logic fire_o,
  output logic done_o
);
  logic done_q;

  assign ready_o = rst_ni;
  assign fire_o  = valid_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= fire_o;
  end

  assign done_o = done_q;
endmodule

// File: rtl/seg_rd_pipe.sv
module seg_rd_pipe #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  output logic          fire_o,
  input  logic [DW-1:0] stage_data_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [DW-1:0] rsp_data_o
);
  logic          stage_vld_q;
  logic          rsp_vld_q;
  logic [DW-1:0] rsp_data_q;
  logic          adv;

  assign adv         = rsp_ready_i | ~rsp_vld_q;
  assign cmd_ready_o = rst_ni & (~rsp_vld_q | ~stage_vld_q);
  assign fire_o      = cmd_valid_i & cmd_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_vld_q <= 1'b0;
      rsp_vld_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (adv) begin
        rsp_vld_q <= stage_vld_q;
        if (stage_vld_q) rsp_data_q <= stage_data_i;
      end
      stage_vld_q <= fire_o | (stage_vld_q & ~adv);
    end
  end

  assign rsp_valid_o = rsp_vld_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/seg_dp_ram.sv
module seg_dp_ram
  import seg_dp_ram_pkg::*;
#(
  parameter int SEG_CNT = 2,
  parameter int SEG_AW  = 4,
  parameter int SEG_DW  = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [SEG_CNT-1:0]               wr_valid_i,
  output logic [SEG_CNT-1:0]               wr_ready_o,
  input  logic [SEG_CNT*SEG_AW-1:0]        wr_addr_i,
  input  logic [SEG_CNT*SEG_DW-1:0]        wr_data_i,
  input  logic [SEG_CNT*SEG_DW/BYTE_W-1:0] wr_be_i,
  output logic [SEG_CNT-1:0]               wr_done_o,
  input  logic [SEG_CNT-1:0]               rd_valid_i,
  output logic [SEG_CNT-1:0]               rd_ready_o,
  input  logic [SEG_CNT*SEG_AW-1:0]        rd_addr_i,
  output logic [SEG_CNT*SEG_DW-1:0]        rd_data_o,
  output logic [SEG_CNT-1:0]               rd_rvalid_o,
  input  logic [SEG_CNT-1:0]               rd_rready_i
);
  localparam int BE_W = SEG_DW / BYTE_W;

  for (genvar s = 0; s < SEG_CNT; s++) begin : g_seg
    logic              wr_fire;
    logic              rd_fire;
    logic [SEG_DW-1:0] stage_data;

    seg_wr_port u_wr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (wr_valid_i[s]),
      .ready_o (wr_ready_o[s]),
      .fire_o  (wr_fire),
      .done_o  (wr_done_o[s])
    );

    seg_bank #(.AW(SEG_AW), .DW(SEG_DW)) u_bank (
      .clk_i   (clk_i),
      .we_i    (wr_fire),
      .waddr_i (wr_addr_i[s*SEG_AW +: SEG_AW]),
      .wdata_i (wr_data_i[s*SEG_DW +: SEG_DW]),
      .wbe_i   (wr_be_i[s*BE_W +: BE_W]),
      .re_i    (rd_fire),
      .raddr_i (rd_addr_i[s*SEG_AW +: SEG_AW]),
      .rdata_o (stage_data)
    );

    seg_rd_pipe #(.DW(SEG_DW)) u_rd (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cmd_valid_i  (rd_valid_i[s]),
      .cmd_ready_o  (rd_ready_o[s]),
      .fire_o       (rd_fire),
      .stage_data_i (stage_data),
      .rsp_valid_o  (rd_rvalid_o[s]),
      .rsp_ready_i  (rd_rready_i[s]),
      .rsp_data_o   (rd_data_o[s*SEG_DW +: SEG_DW])
    );
  end
endmodule

// File: rtl/seg_dp_ram_chk.sv
module seg_dp_ram_chk #(
  parameter int SEG_CNT = 2,
  parameter int SEG_AW  = 4,
  parameter int SEG_DW  = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [SEG_CNT-1:0]          wr_valid_i,
  input logic [SEG_CNT-1:0]          wr_ready_o,
  input logic [SEG_CNT-1:0]          wr_done_o,
  input logic [SEG_CNT-1:0]          rd_ready_o,
  input logic [SEG_CNT*SEG_DW-1:0]   rd_data_o,
  input logic [SEG_CNT-1:0]          rd_rvalid_o,
  input logic [SEG_CNT-1:0]          rd_rready_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (wr_ready_o == '0 && rd_ready_o == '0 &&
                               rd_rvalid_o == '0 && wr_done_o == '0); // R8
    end
  end

  for (genvar s = 0; s < SEG_CNT; s++) begin : g_chk
    AST_DONE_FOLLOWS_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_valid_i[s] && wr_ready_o[s] |=> wr_done_o[s]); // R4
    AST_DONE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_done_o[s] |-> $past(wr_valid_i[s] && wr_ready_o[s])); // R4
    AST_RSP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_rvalid_o[s] && !rd_rready_i[s] |=>
        rd_rvalid_o[s] && $stable(rd_data_o[s*SEG_DW +: SEG_DW])); // R6
    AST_STALL_ONLY_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_ready_o[s] |-> rd_rvalid_o[s]); // R7
    AST_WR_ALWAYS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_ready_o[s]); // R7
  end
endmodule

bind seg_dp_ram seg_dp_ram_chk #(
  .SEG_CNT (SEG_CNT),
  .SEG_AW  (SEG_AW),
  .SEG_DW  (SEG_DW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .wr_ready_o  (wr_ready_o),
  .wr_done_o   (wr_done_o),
  .rd_ready_o  (rd_ready_o),
  .rd_data_o   (rd_data_o),
  .rd_rvalid_o (rd_rvalid_o),
  .rd_rready_i (rd_rready_i)
);

// File: tb/seg_dp_ram_tb.sv
module seg_dp_ram_tb;
  localparam int SEG = 2;
  localparam int AW  = 3;
  localparam int DW  = 16;
  localparam int BEW = DW / 8;
  localparam int NB  = SEG * (1 << AW) * BEW;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [SEG-1:0]      wr_valid = '0, wr_ready, wr_done;
  logic [SEG*AW-1:0]   wr_addr = '0;
  logic [SEG*DW-1:0]   wr_data = '0;
  logic [SEG*BEW-1:0]  wr_be = '0;
  logic [SEG-1:0]      rd_valid = '0, rd_ready, rd_rvalid;
  logic [SEG-1:0]      rd_rready = '1;
  logic [SEG*AW-1:0]   rd_addr = '0;
  logic [SEG*DW-1:0]   rd_data;

  logic [7:0] mem_m [NB];
  int n_vec = 0;
  int n_err = 0;
  bit done_run = 0;

  always #2.5 clk = ~clk;

  seg_dp_ram #(.SEG_CNT(SEG), .SEG_AW(AW), .SEG_DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_be_i(wr_be), .wr_done_o(wr_done),
    .rd_valid_i(rd_valid), .rd_ready_o(rd_ready), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rd_rvalid_o(rd_rvalid), .rd_rready_i(rd_rready)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int base_of(int s, int a);
    return (a * SEG + s) * BEW;   // flat byte address of segment s, address a
  endfunction

  function automatic logic [DW-1:0] exp_word(int s, int a);
    logic [DW-1:0] w;
    for (int k = 0; k < BEW; k++) w[k*8 +: 8] = mem_m[base_of(s, a) + k];
    return w;
  endfunction

  function automatic logic [DW-1:0] pat(int s, int a);
    logic [DW-1:0] w;
    for (int k = 0; k < BEW; k++) w[k*8 +: 8] = 8'((base_of(s, a) + k) * 37 + 11);
    return w;
  endfunction

  task automatic wr_go(input logic [SEG-1:0] m, input logic [SEG*AW-1:0] a,
                       input logic [SEG*DW-1:0] d, input logic [SEG*BEW-1:0] be);
    @(negedge clk);
    wr_valid = m; wr_addr = a; wr_data = d; wr_be = be;
    for (int s = 0; s < SEG; s++) if (m[s]) chk("R7 wr ready", 64'(wr_ready[s]), 64'd1);
    @(negedge clk);
    wr_valid = '0;
    for (int s = 0; s < SEG; s++) begin
      chk("R4 done pulse", 64'(wr_done[s]), 64'(m[s]));
      if (m[s]) for (int k = 0; k < BEW; k++)
        if (be[s*BEW + k]) mem_m[base_of(s, int'(a[s*AW +: AW])) + k] = d[s*DW + k*8 +: 8];
    end
    @(negedge clk);
    chk("R4 done one cycle", 64'(wr_done), 64'd0);
  endtask

  task automatic rd_go(input logic [SEG-1:0] m, input logic [SEG*AW-1:0] a);
    @(negedge clk);
    rd_valid = m; rd_addr = a;
    for (int s = 0; s < SEG; s++) if (m[s]) chk("R7 rd ready idle", 64'(rd_ready[s]), 64'd1);
    @(negedge clk);
    rd_valid = '0;
    for (int s = 0; s < SEG; s++) if (m[s]) chk("R5 not after one edge", 64'(rd_rvalid[s]), 64'd0);
    @(negedge clk);
    for (int s = 0; s < SEG; s++) if (m[s]) begin
      chk("R5 valid after two edges", 64'(rd_rvalid[s]), 64'd1);
      chk("R1 R2 R3 read data", 64'(rd_data[s*DW +: DW]), 64'(exp_word(s, int'(a[s*AW +: AW]))));
    end
    @(negedge clk);
    for (int s = 0; s < SEG; s++) if (m[s]) chk("R5 drained", 64'(rd_rvalid[s]), 64'd0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      n_err++;
      n_vec++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] held;
    logic [DW-1:0] old_w;
    for (int i = 0; i < NB; i++) mem_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R8 reset wr_ready", 64'(wr_ready), 64'd0);
    chk("R8 reset rd_ready", 64'(rd_ready), 64'd0);
    chk("R8 reset rvalid", 64'(rd_rvalid), 64'd0);
    chk("R8 reset done", 64'(wr_done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 ready after reset", 64'({wr_ready, rd_ready}), 64'({SEG{2'b11}}));

    // fill: both segments at once, different addresses per field
    for (int a = 0; a < (1 << AW); a++)
      wr_go(2'b11, {3'(7 - a), 3'(a)}, {pat(1, 7 - a), pat(0, a)}, '1);
    for (int a = 0; a < (1 << AW); a++) rd_go(2'b11, {3'(a), 3'(a)});
    rd_go(2'b10, {3'd5, 3'd0});
    rd_go(2'b01, {3'd0, 3'd6});

    // R3: byte-enable sweep on segment 0, address 3
    for (int be = 0; be < (1 << BEW); be++) begin
      wr_go(2'b01, {3'd0, 3'd3}, {16'h0, 16'(16'hA55A + be * 16'h1111)}, {2'b00, 2'(be)});
      rd_go(2'b11, {3'd3, 3'd3});
    end

    // R6 R7 R10: stall segment 0 response
    rd_rready = 2'b10;
    @(negedge clk); rd_valid = 2'b01; rd_addr = {3'd0, 3'd1};
    @(negedge clk); rd_valid = '0;
    @(negedge clk);
    chk("R6 first rsp valid", 64'(rd_rvalid[0]), 64'd1);
    chk("R6 first rsp data", 64'(rd_data[DW-1:0]), 64'(exp_word(0, 1)));
    held = rd_data[DW-1:0];
    chk("R7 ready with free stage", 64'(rd_ready[0]), 64'd1);
    rd_valid = 2'b01; rd_addr = {3'd0, 3'd2};
    @(negedge clk); rd_valid = '0;
    chk("R7 ready low when full", 64'(rd_ready[0]), 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 valid held", 64'(rd_rvalid[0]), 64'd1);
      chk("R6 data held", 64'(rd_data[DW-1:0]), 64'(held));
      chk("R7 still stalled", 64'(rd_ready[0]), 64'd0);
    end
    rd_go(2'b10, {3'd4, 3'd0});
    chk("R10 seg0 unaffected", 64'(rd_data[DW-1:0]), 64'(held));
    chk("R10 seg0 still valid", 64'(rd_rvalid[0]), 64'd1);
    @(negedge clk); rd_rready = 2'b11;
    @(negedge clk);
    chk("R6 queued valid", 64'(rd_rvalid[0]), 64'd1);
    chk("R6 queued data", 64'(rd_data[DW-1:0]), 64'(exp_word(0, 2)));
    @(negedge clk);
    chk("R6 emptied", 64'(rd_rvalid[0]), 64'd0);

    // R9: same word read and written in one cycle
    old_w = exp_word(1, 2);
    @(negedge clk);
    wr_valid = 2'b10; wr_addr = {3'd2, 3'd0}; wr_data = {16'hBEEF, 16'h0}; wr_be = 4'b1100;
    rd_valid = 2'b10; rd_addr = {3'd2, 3'd0};
    @(negedge clk); wr_valid = '0; rd_valid = '0;
    chk("R9 write done", 64'(wr_done[1]), 64'd1);
    mem_m[base_of(1, 2)] = 8'hEF; mem_m[base_of(1, 2) + 1] = 8'hBE;
    @(negedge clk);
    chk("R9 old data valid", 64'(rd_rvalid[1]), 64'd1);
    chk("R9 old data", 64'(rd_data[DW +: DW]), 64'(old_w));
    @(negedge clk);
    rd_go(2'b10, {3'd2, 3'd0});

    // R8: reset drops a pending response
    rd_rready = 2'b00;
    @(negedge clk); rd_valid = 2'b01; rd_addr = {3'd0, 3'd5};
    @(negedge clk); rd_valid = '0;
    @(negedge clk);
    chk("R8 pending before reset", 64'(rd_rvalid[0]), 64'd1);
    rst_n = 1'b0;
    #1;
    chk("R8 outputs low in reset", 64'({wr_ready, rd_ready, rd_rvalid, wr_done}), 64'd0);
    @(negedge clk); rst_n = 1'b1; rd_rready = '1;
    @(negedge clk);
    chk("R8 response dropped", 64'(rd_rvalid), 64'd0);
    rd_go(2'b01, {3'd0, 3'd5});

    done_run = 1;
    finish_run();
  end
endmodule